// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Burst SRAM

This block is a cycle-accurate, synthesizable model of a single-port synchronous SRAM. It accepts a read or a write command on every clock, and any mix of the two may follow back to back with no idle cycle. Every input is captured on the rising clock edge. Read data leaves through an output register two enabled clocks after its command. Write data is taken on the bus two enabled clocks after its command. That symmetry is what lets the data bus turn around between reads and writes without a bubble.

A write is retired into the array one enabled cycle after its data arrives. A read that targets a word whose write is still waiting is served from that pending write, merged lane by lane. A loaded address can be followed by advance cycles that step through the other three words of its aligned group of four, in either linear or interleaved order. A clock-enable input freezes the whole block. A sleep input parks it with the outputs switched off. A `dout_en` flag stands in for a tri-state data bus.

Top module: `zbt_sram`

## Requirements
- R1: After reset, `dout_en` is 0, `dout` is 0 and no burst is active, so advance cycles issued straight after reset cause no access.
- R2: A command sampled with `cke`=1, `sleep`=0 and `adv_ld`=0 while selected is a read if `we`=0 and a write if `we`=1. A read's word is on `dout` with `dout_en`=1 after the second enabled edge that follows the command edge. A write's data is sampled from `din` at that second enabled edge. Reads and writes may follow on consecutive cycles in any order.
- R3: A read always returns the newest data written to its address, including data whose write has not yet been retired into the array.
- R4: The word is split into lanes of 9 bits, with lane i at bits [9i+8:9i]. A write updates lane i only when `bw[i]`=1. A write with `bw`=0 leaves the word unchanged.
- R5: A load sets the burst start address. Each following advance (`adv_ld`=1) with `cke`=1 moves one beat. The upper address bits stay fixed, and the low two bits become (start+beat) mod 4 when `burst_il`=0, or start XOR beat when `burst_il`=1. The beat count wraps modulo 4.
- R6: An advance repeats the burst's operation whatever `we` and the chip selects are, and takes `bw` from its own cycle, so `bw`=0 on an advance aborts that beat's write. An advance with no active burst performs no access.
- R7: While `cke`=0 (and `sleep`=0), all inputs are ignored and `dout`, `dout_en`, the pipeline and the array hold.
- R8: `dout_en` is 0 and `dout` is 0 after every enabled edge that is not a read data phase, including every write data phase.
- R9: A load is selected only when `cs_a`=1, `cs_b`=1 and `cs_c_n`=0. A load with any other combination is a deselect: it performs no access and ends any burst.
- R10: While `sleep`=1, commands are ignored and `dout_en` is 0. `dout_en` is still 0 on the first cycle after sleep ends, and the array contents are retained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable; 0 freezes the block |
| addr | input | ADDR_W | Word address for load cycles |
| adv_ld | input | 1 | 1 = advance burst, 0 = load new command |
| we | input | 1 | 1 = write, 0 = read on load cycles |
| bw | input | LANES | Per-lane write selects |
| cs_a | input | 1 | Chip select, active high |
| cs_b | input | 1 | Chip select, active high |
| cs_c_n | input | 1 | Chip select, active low |
| burst_il | input | 1 | 1 = interleaved, 0 = linear burst order |
| sleep | input | 1 | Low-power park request |
| din | input | LANES*LANE_W | Write data bus |
| dout | output | LANES*LANE_W | Registered read data |
| dout_en | output | 1 | Output drive enable (tri-state stand-in) |

## Verification
The assertions assume that sleep is requested only once two deselect cycles have emptied the command pipeline, and that `burst_il` stays constant during a burst. The stimulus always issues two deselects before raising sleep, and changes the burst order only between bursts. The random mixed stream draws addresses from a group of eight words, so that pending writes are hit often. It drops `cke` at random points, so that stalls land between commands and their data phases.

// File: rtl/zbt_pkg.sv
`timescale 1ns/1ps
package zbt_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Low two address bits of a burst beat.
    function automatic logic [1:0] beat_offset(input logic [1:0] start,
                                               input logic [1:0] beat,
                                               input logic       interleave);
        return interleave ? (start ^ beat) : (start + beat);
    endfunction

endpackage

// File: rtl/zbt_burst_addr.sv
`timescale 1ns/1ps
module zbt_burst_addr
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [1:0]        beat,
    input  logic              interleave,
    output logic [ADDR_W-1:0] beat_addr
);

    localparam int HI_W = ADDR_W - 2;

    logic [HI_W-1:0] hi_bits;
    logic [1:0]      lo_bits;

    always_comb begin
        hi_bits   = base[ADDR_W-1:2];
        lo_bits   = beat_offset(base[1:0], beat, interleave);
        beat_addr = {hi_bits, lo_bits};
    end

endmodule

// File: rtl/zbt_lane_store.sv
`timescale 1ns/1ps
module zbt_lane_store #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    commit,
    input  logic                    pend_valid,
    input  logic [ADDR_W-1:0]       pend_addr,
    input  logic [LANES-1:0]        pend_bw,
    input  logic [LANES*LANE_W-1:0] pend_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic hit;
    assign hit = pend_valid && (pend_addr == rd_addr);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem_q [DEPTH];
        logic [LANE_W-1:0] arr_word;

        always_ff @(posedge clk) begin
            if (commit && pend_valid && pend_bw[g]) begin
                mem_q[pend_addr] <= pend_data[g*LANE_W +: LANE_W];
            end
        end

        always_comb begin
            arr_word = mem_q[rd_addr];
            rd_data[g*LANE_W +: LANE_W] = (hit && pend_bw[g])
                ? pend_data[g*LANE_W +: LANE_W] : arr_word;
        end
    end

endmodule

// File: rtl/zbt_sram.sv
`timescale 1ns/1ps
module zbt_sram
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cke,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    adv_ld,
    input  logic                    we,
    input  logic [LANES-1:0]        bw,
    input  logic                    cs_a,
    input  logic                    cs_b,
    input  logic                    cs_c_n,
    input  logic                    burst_il,
    input  logic                    sleep,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_en
);

    localparam int DATA_W = LANES * LANE_W;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  bw;
    } cmd_t;

    typedef struct packed {
        logic              burst_act;
        op_e               burst_op;
        logic [ADDR_W-1:0] burst_base;
        logic [1:0]        burst_beat;
        cmd_t              stage1;
        cmd_t              stage2;
        logic              pend_v;
        logic [ADDR_W-1:0] pend_a;
        logic [LANES-1:0]  pend_b;
        logic [DATA_W-1:0] pend_d;
        logic [DATA_W-1:0] out_d;
        logic              out_en;
    } state_t;

    state_t st_q, st_d;

    logic              step;
    logic              selected;
    logic [1:0]        next_beat;
    logic [ADDR_W-1:0] adv_addr;
    logic [DATA_W-1:0] rd_word;

    assign step      = cke | sleep;
    assign selected  = cs_a & cs_b & ~cs_c_n;
    assign next_beat = st_q.burst_beat + 2'd1;

    zbt_burst_addr #(.ADDR_W(ADDR_W)) u_burst (
        .base       (st_q.burst_base),
        .beat       (next_beat),
        .interleave (burst_il),
        .beat_addr  (adv_addr)
    );

    zbt_lane_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
        .clk        (clk),
        .commit     (step),
        .pend_valid (st_q.pend_v),
        .pend_addr  (st_q.pend_a),
        .pend_bw    (st_q.pend_b),
        .pend_data  (st_q.pend_d),
        .rd_addr    (st_q.stage2.addr),
        .rd_data    (rd_word)
    );

    always_comb begin
        st_d = st_q;
        if (step) begin
            // data phase of the command issued two enabled cycles ago
            st_d.pend_v = 1'b0;
            st_d.out_d  = '0;
            st_d.out_en = 1'b0;
            if (st_q.stage2.op == OP_READ && !sleep) begin
                st_d.out_d  = rd_word;
                st_d.out_en = 1'b1;
            end
            if (st_q.stage2.op == OP_WRITE) begin
                st_d.pend_v = 1'b1;
                st_d.pend_a = st_q.stage2.addr;
                st_d.pend_b = st_q.stage2.bw;
                st_d.pend_d = din;
            end

            // pipeline shift
            st_d.stage2    = st_q.stage1;
            st_d.stage1.op = OP_IDLE;

            // new command
            if (sleep) begin
                st_d.burst_act = 1'b0;
            end else if (!adv_ld) begin
                if (selected) begin
                    st_d.burst_act  = 1'b1;
                    st_d.burst_op   = we ? OP_WRITE : OP_READ;
                    st_d.burst_base = addr;
                    st_d.burst_beat = 2'd0;
                    st_d.stage1     = '{op: (we ? OP_WRITE : OP_READ), addr: addr, bw: bw};
                end else begin
                    st_d.burst_act = 1'b0;
                end
            end else if (st_q.burst_act) begin
                st_d.burst_beat = next_beat;
                st_d.stage1     = '{op: st_q.burst_op, addr: adv_addr, bw: bw};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout    = st_q.out_d;
    assign dout_en = st_q.out_en;

    // A stalled cycle leaves the output register untouched.
    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && !sleep) |=> ($stable(dout) && $stable(dout_en)));

    // Sleep never drives the bus.
    assert_sleep_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !dout_en);

    // Sleep is requested only with an empty command pipeline.
    assert_sleep_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep) |-> (st_q.stage1.op == OP_IDLE && st_q.stage2.op == OP_IDLE));

    // The bus is released during every write data phase.
    assert_write_phase_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step && st_q.stage2.op == OP_WRITE) |=> !dout_en);

    // A burst beat never leaves its group of four words.
    assert_burst_group_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && !sleep && adv_ld && st_q.burst_act)
            |=> (st_q.stage1.addr[ADDR_W-1:2] == $past(st_q.stage1.addr[ADDR_W-1:2])));

endmodule

// File: tb/zbt_sram_tb.sv
`timescale 1ns/1ps
module zbt_sram_tb;

    localparam int AW = 6;
    localparam int NL = 4;
    localparam int LW = 9;
    localparam int DW = NL * LW;
    localparam int K_DS  = 0;
    localparam int K_RD  = 1;
    localparam int K_WR  = 2;
    localparam int K_ADV = 3;
    localparam int K_BAD = 4;

    logic          clk = 1'b0;
    logic          rst_n, cke, adv_ld, we, cs_a, cs_b, cs_c_n, burst_il, sleep;
    logic [AW-1:0] addr;
    logic [NL-1:0] bw;
    logic [DW-1:0] din;
    logic [DW-1:0] dout;
    logic          dout_en;

    always #2 clk = ~clk;

    zbt_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .addr(addr), .adv_ld(adv_ld),
        .we(we), .bw(bw), .cs_a(cs_a), .cs_b(cs_b), .cs_c_n(cs_c_n),
        .burst_il(burst_il), .sleep(sleep), .din(din), .dout(dout), .dout_en(dout_en)
    );

    int checks = 0;
    int errors = 0;

    // bench-side model
    logic [DW-1:0] mem_m [1<<AW];
    logic          pv [2];
    logic          pwr [2];
    logic [AW-1:0] pa [2];
    logic [NL-1:0] pb [2];
    logic          b_act, b_wr;
    logic [AW-1:0] b_base;
    logic [1:0]    b_beat;
    logic          exp_en;
    logic [DW-1:0] exp_d;
    logic          mode_b = 1'b0;
    logic          adv_we = 1'b0;
    logic [2:0]    adv_cs = 3'b011;
    logic [2:0]    bad_cs = 3'b000;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic merge(input logic [AW-1:0] a, input logic [NL-1:0] b, input logic [DW-1:0] d);
        for (int i = 0; i < NL; i++) begin
            if (b[i]) mem_m[a][i*LW +: LW] = d[i*LW +: LW];
        end
    endtask

    task automatic step(input int kind, input logic [AW-1:0] a, input logic [NL-1:0] b,
                        input bit en, input bit slp, input string tag);
        logic [2:0]    csv;
        logic [63:0]   r;
        logic [DW-1:0] wd;
        logic          nv, nwr;
        logic [AW-1:0] na;
        logic [1:0]    lo;
        @(negedge clk);
        csv = (kind == K_RD || kind == K_WR) ? 3'b011 :
              (kind == K_DS) ? 3'b010 : (kind == K_BAD) ? bad_cs : adv_cs;
        cs_a = csv[0]; cs_b = csv[1]; cs_c_n = csv[2];
        adv_ld = (kind == K_ADV);
        we = (kind == K_WR) ? 1'b1 : (kind == K_RD) ? 1'b0 :
             (kind == K_ADV) ? adv_we : 1'($urandom);
        addr = a; bw = b; cke = en; sleep = slp; burst_il = mode_b;
        r = {$urandom, $urandom};
        wd = r[DW-1:0];
        din = wd;
        @(posedge clk);
        if (slp) begin
            exp_en = 1'b0; exp_d = '0;
            if (pv[1] && pwr[1]) merge(pa[1], pb[1], wd);
            pv[1] = pv[0]; pwr[1] = pwr[0]; pa[1] = pa[0]; pb[1] = pb[0];
            pv[0] = 1'b0; b_act = 1'b0;
        end else if (en) begin
            if (pv[1] && !pwr[1]) begin
                exp_en = 1'b1; exp_d = mem_m[pa[1]];
            end else begin
                exp_en = 1'b0; exp_d = '0;
                if (pv[1]) merge(pa[1], pb[1], wd);
            end
            pv[1] = pv[0]; pwr[1] = pwr[0]; pa[1] = pa[0]; pb[1] = pb[0];
            nv = 1'b0; nwr = 1'b0; na = '0;
            if (kind != K_ADV) begin
                if (csv == 3'b011) begin
                    b_act = 1'b1; b_wr = (kind == K_WR) ? 1'b1 : (kind == K_RD) ? 1'b0 : we;
                    b_base = a; b_beat = 2'd0;
                    nv = 1'b1; nwr = b_wr; na = a;
                end else begin
                    b_act = 1'b0;
                end
            end else if (b_act) begin
                b_beat = b_beat + 2'd1;
                lo = mode_b ? (b_base[1:0] ^ b_beat) : (b_base[1:0] + b_beat);
                nv = 1'b1; nwr = b_wr; na = {b_base[AW-1:2], lo};
            end
            pv[0] = nv; pwr[0] = nwr; pa[0] = na; pb[0] = b;
        end
        #1;
        chk(dout_en === exp_en, tag, "dout_en", DW'(dout_en), DW'(exp_en));
        chk(dout === exp_d, tag, "dout", dout, exp_d);
    endtask

    task automatic drain(input string tag);
        step(K_DS, '0, '0, 1'b1, 1'b0, tag);
        step(K_DS, '0, '0, 1'b1, 1'b0, tag);
        step(K_DS, '0, '0, 1'b1, 1'b0, tag);
    endtask

    initial begin
        #(50000 * 4);
        errors++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cke = 1'b1; adv_ld = 1'b0; we = 1'b0; cs_a = 1'b0; cs_b = 1'b0;
        cs_c_n = 1'b1; burst_il = 1'b0; sleep = 1'b0; addr = '0; bw = '0; din = '0;
        pv[0] = 0; pv[1] = 0; pwr[0] = 0; pwr[1] = 0; pa[0] = 0; pa[1] = 0; pb[0] = 0; pb[1] = 0;
        b_act = 0; b_wr = 0; b_base = 0; b_beat = 0; exp_en = 0; exp_d = '0;
        for (int i = 0; i < (1 << AW); i++) mem_m[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(dout_en === 1'b0, "R1", "reset dout_en", DW'(dout_en), '0);
        chk(dout === '0, "R1", "reset dout", dout, '0);
        // R1: advances right after reset do nothing
        step(K_ADV, '0, '1, 1'b1, 1'b0, "R1");
        step(K_ADV, '0, '1, 1'b1, 1'b0, "R1");
        step(K_ADV, '0, '1, 1'b1, 1'b0, "R1");

        // R2: fill every word with back-to-back writes, read all back
        for (int a = 0; a < (1 << AW); a++) step(K_WR, AW'(a), '1, 1'b1, 1'b0, "R2");
        for (int a = 0; a < (1 << AW); a++) step(K_RD, AW'(a), '0, 1'b1, 1'b0, "R2");
        // R2: alternating reads and writes every cycle
        for (int a = 0; a < 32; a++)
            step((a % 2) ? K_RD : K_WR, AW'(a * 3), '1, 1'b1, 1'b0, "R2");
        drain("R2");

        // R3: read right behind a write to the same word
        for (int a = 0; a < 8; a++) begin
            step(K_WR, AW'(a + 40), '1, 1'b1, 1'b0, "R3");
            step(K_RD, AW'(a + 40), '0, 1'b1, 1'b0, "R3");
            step(K_RD, AW'(a + 40), '0, 1'b1, 1'b0, "R3");
            step(K_WR, AW'(a + 40), 4'b0101, 1'b1, 1'b0, "R3");
            step(K_RD, AW'(a + 40), '0, 1'b1, 1'b0, "R3");
        end
        drain("R3");

        // R4: every lane-select pattern, including the empty one
        for (int b = 0; b < 16; b++) begin
            step(K_WR, AW'(5), NL'(b), 1'b1, 1'b0, "R4");
            step(K_RD, AW'(5), '0, 1'b1, 1'b0, "R4");
        end
        drain("R4");

        // R5: bursts in both orders from every start offset, both operations
        for (int m = 0; m < 2; m++) begin
            for (int o = 0; o < 4; o++) begin
                for (int w = 0; w < 2; w++) begin
                    mode_b = 1'(m); adv_we = 1'(w); adv_cs = 3'b011;
                    step(w ? K_WR : K_RD, AW'(16 + 4 * (o + 1) + o), '1, 1'b1, 1'b0, "R5");
                    for (int k = 0; k < 4; k++) step(K_ADV, '0, '1, 1'b1, 1'b0, "R5");
                    drain("R5");
                    step(K_RD, AW'(16 + 4 * (o + 1)), '0, 1'b1, 1'b0, "R5");
                    for (int k = 0; k < 3; k++) step(K_ADV, '0, '0, 1'b1, 1'b0, "R5");
                    drain("R5");
                end
            end
        end
        mode_b = 1'b0;

        // R6: advance ignores we and chip selects; bw=0 aborts a beat
        adv_we = 1'b1; adv_cs = 3'b100;
        step(K_RD, AW'(8), '0, 1'b1, 1'b0, "R6");
        step(K_ADV, '0, '1, 1'b1, 1'b0, "R6");
        step(K_ADV, '0, '1, 1'b1, 1'b0, "R6");
        adv_we = 1'b0;
        step(K_WR, AW'(12), '1, 1'b1, 1'b0, "R6");
        step(K_ADV, '0, '0, 1'b1, 1'b0, "R6");
        step(K_ADV, '0, 4'b1000, 1'b1, 1'b0, "R6");
        step(K_DS, '0, '0, 1'b1, 1'b0, "R6");
        step(K_ADV, '0, '1, 1'b1, 1'b0, "R6");
        step(K_ADV, '0, '1, 1'b1, 1'b0, "R6");
        for (int a = 12; a < 16; a++) step(K_RD, AW'(a), '0, 1'b1, 1'b0, "R6");
        drain("R6");
        adv_cs = 3'b011;

        // R7: stalls dropped between commands and their data phases
        for (int i = 0; i < 40; i++) begin
            step((i % 3 == 0) ? K_WR : K_RD, AW'(i % 6), NL'($urandom), 1'b1, 1'b0, "R7");
            step(int'($urandom % 4), AW'($urandom), NL'($urandom), 1'b0, 1'b0, "R7");
        end
        drain("R7");

        // R9: every unselecting chip-select combination
        for (int c = 0; c < 8; c++) begin
            if (c != 3) begin
                bad_cs = 3'(c);
                step(K_RD, AW'(c), '0, 1'b1, 1'b0, "R9");
                step(K_BAD, AW'(c + 1), '1, 1'b1, 1'b0, "R9");
                step(K_ADV, '0, '1, 1'b1, 1'b0, "R9");
                drain("R9");
            end
        end

        // R10: sleep after two deselects, commands ignored, clean exit
        step(K_DS, '0, '0, 1'b1, 1'b0, "R10");
        step(K_DS, '0, '0, 1'b1, 1'b0, "R10");
        for (int i = 0; i < 4; i++)
            step(int'($urandom % 3), AW'($urandom), '1, 1'($urandom), 1'b1, "R10");
        step(K_DS, '0, '0, 1'b1, 1'b0, "R10");
        step(K_RD, AW'(40), '0, 1'b1, 1'b0, "R10");
        step(K_RD, AW'(41), '0, 1'b1, 1'b0, "R10");
        drain("R10");

        // R8 and R3: random mixed stream on a small address group
        for (int i = 0; i < 400; i++) begin
            adv_we = 1'($urandom); adv_cs = 3'($urandom);
            step(int'($urandom % 4), AW'($urandom % 8), NL'($urandom),
                 ($urandom % 5) != 0, 1'b0, (i % 2) ? "R3" : "R8");
        end
        drain("R8");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule